// File: doc/BRIEF.md
# Two-Way Instruction Cache Tag and Control Unit

This unit keeps the bookkeeping side of a small two-way set-associative instruction cache. For every set and way it stores a tag, a tag-valid flag, one valid flag per sub-block, and an entry-lock flag. Each set also has a replacement bit that names the way to evict next. A fetch lookup port compares an address against both ways of the addressed set and reports hit and hit way in the same cycle. A fill port installs a tag and a sub-block valid flag after a miss. A six-bit control register sets the unit's behaviour and reports its status.

The unit has a few unusual rules. A flush request does not act at once: it waits for the next fetch access and then invalidates every tag-valid flag from the following cycle on. A flush leaves tags, sub-block flags, replacement bits and locks untouched. Locks survive a flush and are removed only by the release bit. While the cache is disabled, the storage arrays are frozen, but the control register can still be written and a flush still completes. The data RAM, the refill engine and the fetch pipeline are outside this unit.

Top module: `icache_tag_ctrl`

## Requirements
- R1: After reset the control register reads 0. Its bits are: bit 0 enable, bit 1 flush pending, bit 2 global lock, bit 3 auto-lock, bit 4 lock release pending, bit 5 auto-lock fail. The storage array contents are undefined after reset.
- R2: A lookup hits only when all of these hold: the cache is enabled, a way's tag-valid flag is set, that way's tag equals the address tag, and the valid flag of the addressed sub-block is set. `fetchWay` gives the hitting way. The fetch address is packed as {tag, set index, sub-block}, with the sub-block in the least significant bits.
- R3: A fill that misses allocates a line and marks only the filled sub-block valid. A fill whose tag is already valid in the set adds that sub-block to the existing way.
- R4: The victim is the lowest-numbered way whose tag is invalid. If both ways are valid, the victim is the way named by the set's replacement bit. A hit or a fill on a way points the replacement bit at the other way.
- R5: A locked way is never chosen as victim. With auto-lock on, every filled entry becomes locked.
- R6: A fill that misses in a set whose two ways are both locked changes nothing and sets the fail bit. A register write with bit 5 at 0 clears the fail bit.
- R7: While disabled, every lookup misses and fills are ignored. Tags, sub-block flags, replacement bits and locks keep their values, and earlier lines hit again once the cache is re-enabled.
- R8: All control bits can be written and read back while the cache is disabled.
- R9: Writing 1 to the flush bit sets it pending. The lookup in the next fetch access cycle still sees the old contents. From the following cycle on, every tag-valid flag is clear and the flush bit reads 0. This also happens while the cache is disabled.
- R10: Entry locks stay set across a flush.
- R11: Writing 1 to the release bit clears all entry locks one cycle after the cache is enabled, and the bit then returns to 0. While the cache is disabled, the release request stays pending.
- R12: While the global lock bit is set, fills are ignored and lookups still hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset of the control register |
| fetchReq | input | 1 | Fetch access this cycle (also the trigger for a pending flush) |
| fetchAddr | input | ADDR_W | Fetch address {tag, set, sub-block} |
| fetchHit | output | 1 | Lookup hit, combinational |
| fetchWay | output | 1 | Way that hit |
| fillReq | input | 1 | Install request |
| fillAddr | input | ADDR_W | Address being installed |
| regWe | input | 1 | Control register write strobe |
| regWdata | input | 6 | Control register write value |
| regRdata | output | 6 | Control register contents |

## Verification
The internal state shows up at the ports in two ways. A corrupt tag-valid flag, tag or sub-block flag turns the very next lookup of that line into a wrong hit or miss. A wrong replacement or lock bit stays hidden until a later fill evicts the wrong way, and only a lookup of the evicted or kept line reveals it. For that reason the tests build exact fill sequences in a set, with both ways known, before they probe. The flush and release delays are checked cycle by cycle through the register readback and through lookups in the access cycle and the cycle after it.

// File: rtl/ictag_pkg.sv
package ictag_pkg;
  localparam int CTRL_W  = 6;
  localparam int B_EN    = 0;
  localparam int B_FLUSH = 1;
  localparam int B_GLOCK = 2;
  localparam int B_AUTO  = 3;
  localparam int B_REL   = 4;
  localparam int B_FAIL  = 5;

  // strobes from control to the storage datapath
  typedef struct packed {
    logic lookupEn;
    logic fillEn;
    logic autoLock;
    logic flushNow;
    logic releaseNow;
  } ctlStrobe_t;
endpackage

// File: rtl/ictag_ctrl.sv
module ictag_ctrl
  import ictag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [CTRL_W-1:0] regWdata,
  output logic [CTRL_W-1:0] regRdata,
  input  logic              fetchReq,
  input  logic              fillReq,
  input  logic              fillFail,
  output ctlStrobe_t        st
);
  logic enR, flushR, gLockR, autoLockR, releaseR, failR;

  always_comb begin
    st            = '0;
    st.lookupEn   = enR;
    st.fillEn     = enR & ~gLockR & fillReq;
    st.autoLock   = autoLockR;
    st.flushNow   = flushR & fetchReq;
    st.releaseNow = releaseR & enR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enR <= 1'b0; flushR <= 1'b0; gLockR <= 1'b0;
      autoLockR <= 1'b0; releaseR <= 1'b0; failR <= 1'b0;
    end else begin
      if (regWe) begin
        enR       <= regWdata[B_EN];
        gLockR    <= regWdata[B_GLOCK];
        autoLockR <= regWdata[B_AUTO];
      end
      if (regWe && regWdata[B_FLUSH]) flushR <= 1'b1;
      else if (st.flushNow)           flushR <= 1'b0;
      if (regWe && regWdata[B_REL])   releaseR <= 1'b1;
      else if (st.releaseNow)         releaseR <= 1'b0;
      if (fillFail)    failR <= 1'b1;
      else if (regWe)  failR <= regWdata[B_FAIL];
    end
  end

  always_comb begin
    regRdata          = '0;
    regRdata[B_EN]    = enR;
    regRdata[B_FLUSH] = flushR;
    regRdata[B_GLOCK] = gLockR;
    regRdata[B_AUTO]  = autoLockR;
    regRdata[B_REL]   = releaseR;
    regRdata[B_FAIL]  = failR;
  end

  // R9: a flush fired by an access leaves the pending bit clear
  p_flush_selfclear_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.flushNow && !(regWe && regWdata[B_FLUSH]) |=> !regRdata[B_FLUSH]);
  // R11: a release request waits while the cache is disabled
  p_release_waits_r11: assert property (@(posedge clk) disable iff (!rstN)
    releaseR && !enR |=> releaseR);
  // R6: a blocked fill is reported in the register
  p_fail_reported_r6: assert property (@(posedge clk) disable iff (!rstN)
    fillFail |=> regRdata[B_FAIL]);
endmodule

// File: rtl/ictag_arrays.sv
module ictag_arrays
  import ictag_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int SUBS  = 4,
  parameter int TAG_W = 20,
  localparam int IDX_W  = $clog2(SETS),
  localparam int SUB_W  = $clog2(SUBS),
  localparam int ADDR_W = TAG_W + IDX_W + SUB_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        st,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchHit,
  output logic              fetchWay,
  input  logic [ADDR_W-1:0] fillAddr,
  output logic              fillFail
);
  logic [TAG_W-1:0]      tagMem   [SETS][2];
  logic [SUBS-1:0]       subValid [SETS][2];
  logic [SETS-1:0][1:0]  tagValid;
  logic [SETS-1:0][1:0]  lockBit;
  logic [SETS-1:0]       lru;

  logic [SUB_W-1:0] lSub, fSub;
  logic [IDX_W-1:0] lIdx, fIdx;
  logic [TAG_W-1:0] lTag, fTag;
  assign lSub = fetchAddr[SUB_W-1:0];
  assign lIdx = fetchAddr[SUB_W +: IDX_W];
  assign lTag = fetchAddr[ADDR_W-1 -: TAG_W];
  assign fSub = fillAddr[SUB_W-1:0];
  assign fIdx = fillAddr[SUB_W +: IDX_W];
  assign fTag = fillAddr[ADDR_W-1 -: TAG_W];

  logic [1:0] lkMatch, fPresent, fLocks, fValid;
  logic       tgtWay, alloc, fillDo;
  logic [SUBS-1:0] subMask;

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign lkMatch[w]  = tagValid[lIdx][w] && (tagMem[lIdx][w] == lTag)
                         && subValid[lIdx][w][lSub];
    assign fPresent[w] = tagValid[fIdx][w] && (tagMem[fIdx][w] == fTag);
  end

  assign fetchHit = st.lookupEn & fetchReq & (|lkMatch);
  assign fetchWay = fetchHit & lkMatch[1];

  assign fLocks = lockBit[fIdx];
  assign fValid = tagValid[fIdx];

  always_comb begin
    alloc  = 1'b0;
    tgtWay = 1'b0;
    if (|fPresent) begin
      tgtWay = fPresent[1];
    end else begin
      alloc = 1'b1;
      if (fLocks[0])       tgtWay = 1'b1;
      else if (fLocks[1])  tgtWay = 1'b0;
      else if (!fValid[0]) tgtWay = 1'b0;
      else if (!fValid[1]) tgtWay = 1'b1;
      else                 tgtWay = lru[fIdx];
    end
  end

  assign fillFail = st.fillEn & ~(|fPresent) & (&fLocks);
  assign fillDo   = st.fillEn & ~fillFail;
  assign subMask  = {{(SUBS-1){1'b0}}, 1'b1} << fSub;

  always_ff @(posedge clk) begin
    if (fillDo) begin
      if (alloc) begin
        tagMem[fIdx][tgtWay]   <= fTag;
        subValid[fIdx][tgtWay] <= subMask;
      end else begin
        subValid[fIdx][tgtWay][fSub] <= 1'b1;
      end
      lru[fIdx] <= ~tgtWay;
    end
    if (fetchHit && !(fillDo && lIdx == fIdx)) lru[lIdx] <= ~fetchWay;
  end

  always_ff @(posedge clk) begin
    if (st.flushNow)          tagValid <= '0;
    else if (fillDo && alloc) tagValid[fIdx][tgtWay] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (st.releaseNow)              lockBit <= '0;
    else if (fillDo && st.autoLock) lockBit[fIdx][tgtWay] <= 1'b1;
  end

  // R9: after a flush strobe no tag is valid
  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.flushNow |=> tagValid == '0);
  // R11: a release leaves no entry locked
  p_release_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    st.releaseNow |=> lockBit == '0);
  // R7: disabled cache freezes locks and replacement bits
  p_frozen_disabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    !st.lookupEn |=> $stable(lockBit) && $stable(lru));
  // R5: an allocation never lands on a locked way
  p_locked_spared_r5: assert property (@(posedge clk) disable iff (!rstN)
    fillDo && alloc |-> !lockBit[fIdx][tgtWay]);
endmodule

// File: rtl/icache_tag_ctrl.sv
module icache_tag_ctrl
  import ictag_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int SUBS  = 4,
  parameter int TAG_W = 20,
  localparam int ADDR_W = TAG_W + $clog2(SETS) + $clog2(SUBS)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchHit,
  output logic              fetchWay,
  input  logic              fillReq,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic              regWe,
  input  logic [CTRL_W-1:0] regWdata,
  output logic [CTRL_W-1:0] regRdata
);
  ctlStrobe_t st;
  logic       fillFail;

  ictag_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .fetchReq(fetchReq), .fillReq(fillReq),
    .fillFail(fillFail), .st(st)
  );

  ictag_arrays #(.SETS(SETS), .SUBS(SUBS), .TAG_W(TAG_W)) u_arr (
    .clk(clk), .rstN(rstN), .st(st), .fetchReq(fetchReq),
    .fetchAddr(fetchAddr), .fetchHit(fetchHit), .fetchWay(fetchWay),
    .fillAddr(fillAddr), .fillFail(fillFail)
  );
endmodule

// File: tb/sim_icache_tag_ctrl.sv
`timescale 1ns/1ps
module sim_icache_tag_ctrl;
  localparam logic [5:0] EN = 6'd1, FL = 6'd2, GL = 6'd4, AL = 6'd8,
                         RL = 6'd16, FB = 6'd32;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, fetchReq = 1'b0, fillReq = 1'b0, regWe = 1'b0;
  logic [27:0] fetchAddr = '0, fillAddr = '0;
  logic [5:0]  regWdata = '0, regRdata;
  logic fetchHit, fetchWay;
  int nChk = 0, nFail = 0;
  bit finished = 1'b0;

  icache_tag_ctrl u0 (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchHit(fetchHit), .fetchWay(fetchWay), .fillReq(fillReq),
    .fillAddr(fillAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata)
  );

  function automatic logic [27:0] mk(logic [19:0] tag, logic [5:0] idx, logic [1:0] sub);
    return {tag, idx, sub};
  endfunction

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic regWr(logic [5:0] d);
    @(negedge clk); regWe = 1'b1; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic regIs(string req, logic [5:0] exp);
    #1; chk(req, int'(regRdata), int'(exp));
  endtask

  task automatic look(string req, logic [27:0] a, bit expHit, bit expWay);
    @(negedge clk); fetchReq = 1'b1; fetchAddr = a;
    #1; chk(req, int'(fetchHit), int'(expHit));
    if (expHit) chk(req, int'(fetchWay), int'(expWay));
    @(negedge clk); fetchReq = 1'b0;
  endtask

  task automatic access(logic [27:0] a);
    @(negedge clk); fetchReq = 1'b1; fetchAddr = a;
    @(negedge clk); fetchReq = 1'b0;
  endtask

  task automatic fill(logic [27:0] a);
    @(negedge clk); fillReq = 1'b1; fillAddr = a;
    @(negedge clk); fillReq = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    regIs("R1 reset register", 6'd0);
    regWr(EN | RL);
    regWr(EN | FL);
    access(mk(0, 0, 0));
    regIs("R11 initial release done", EN);
  endtask

  task automatic t_hit;
    fill(mk(5, 3, 1));
    look("R2 hit after fill", mk(5, 3, 1), 1, 0);
    look("R3 other sub-block misses", mk(5, 3, 2), 0, 0);
    look("R2 tag mismatch misses", mk(6, 3, 1), 0, 0);
    fill(mk(5, 3, 2));
    look("R3 sub-block added to way", mk(5, 3, 2), 1, 0);
    look("R3 first sub-block kept", mk(5, 3, 1), 1, 0);
  endtask

  task automatic t_victim;
    fill(mk(7, 3, 0));
    look("R4 invalid way taken", mk(7, 3, 0), 1, 1);
    look("R4 way0 hit", mk(5, 3, 1), 1, 0);
    fill(mk(9, 3, 0));
    look("R4 LRU victim evicted", mk(7, 3, 0), 0, 0);
    look("R4 new line in way1", mk(9, 3, 0), 1, 1);
    look("R4 recent line kept", mk(5, 3, 1), 1, 0);
  endtask

  task automatic t_lock;
    regWr(EN | AL);
    fill(mk(1, 11, 0));
    regWr(EN);
    fill(mk(2, 11, 0));
    look("R5 locked line", mk(1, 11, 0), 1, 0);
    look("R5 second line", mk(2, 11, 0), 1, 1);
    fill(mk(3, 11, 0));
    look("R5 locked way spared", mk(1, 11, 0), 1, 0);
    look("R5 unlocked way replaced", mk(3, 11, 0), 1, 1);
    look("R5 evicted line misses", mk(2, 11, 0), 0, 0);
  endtask

  task automatic t_fail;
    regWr(EN | AL);
    fill(mk(1, 12, 0));
    fill(mk(2, 12, 0));
    fill(mk(3, 12, 0));
    regIs("R6 fail bit set", EN | AL | FB);
    look("R6 blocked fill absent", mk(3, 12, 0), 0, 0);
    look("R6 locked way0 intact", mk(1, 12, 0), 1, 0);
    look("R6 locked way1 intact", mk(2, 12, 0), 1, 1);
    regWr(EN);
    regIs("R6 fail bit cleared", EN);
  endtask

  task automatic t_flushLock;
    regWr(EN | FL);
    access(mk(0, 0, 0));
    fill(mk(3, 12, 0));
    regIs("R10 locks survive flush", EN | FB);
    look("R10 fill still blocked", mk(3, 12, 0), 0, 0);
    regWr(RL);
    regIs("R11 release pending while disabled", RL);
    regWr(EN);
    regIs("R11 release still pending at enable", EN | RL);
    @(negedge clk);
    regIs("R11 release self-clears", EN);
    fill(mk(3, 12, 0));
    look("R11 fill after release", mk(3, 12, 0), 1, 0);
  endtask

  task automatic t_disabled;
    fill(mk(4, 20, 0));
    look("R7 enabled hit", mk(4, 20, 0), 1, 0);
    regWr(6'd0);
    look("R7 disabled lookup misses", mk(4, 20, 0), 0, 0);
    fill(mk(5, 20, 0));
    regWr(GL | AL);
    regIs("R8 bits writable while disabled", GL | AL);
    regWr(EN);
    look("R7 line kept while disabled", mk(4, 20, 0), 1, 0);
    look("R7 disabled fill ignored", mk(5, 20, 0), 0, 0);
  endtask

  task automatic t_flush;
    regWr(EN | FL);
    regIs("R9 flush pending", EN | FL);
    repeat (3) @(negedge clk);
    regIs("R9 no access no flush", EN | FL);
    look("R9 access cycle sees old", mk(4, 20, 0), 1, 0);
    look("R9 flushed next cycle", mk(4, 20, 0), 0, 0);
    regIs("R9 flush self-clears", EN);
    fill(mk(4, 20, 0));
    look("R9 refill hits", mk(4, 20, 0), 1, 0);
    regWr(FL);
    access(mk(4, 20, 0));
    regIs("R9 flush done while disabled", 6'd0);
    regWr(EN);
    look("R9 disabled flush took effect", mk(4, 20, 0), 0, 0);
  endtask

  task automatic t_glock;
    fill(mk(6, 30, 0));
    regWr(EN | GL);
    look("R12 hit under global lock", mk(6, 30, 0), 1, 0);
    fill(mk(7, 30, 0));
    regWr(EN);
    look("R12 fill ignored", mk(7, 30, 0), 0, 0);
    look("R12 old line kept", mk(6, 30, 0), 1, 0);
  endtask

  initial begin
    t_reset();
    t_hit();
    t_victim();
    t_lock();
    t_fail();
    t_flushLock();
    t_disabled();
    t_flush();
    t_glock();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: got 0 expected 1 (run ended)");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule